// File: doc/BRIEF.md
# Handshaked Double-Stage Data Buffer with Control/Status Register

This block sits on a 16-bit programmed-I/O register bus and gives software a data word register guarded by two flags. The input-ready flag says the buffer will take a word; the output-ready flag says a word is waiting to be read. Each successful access flips the pair, so the buffer alternates strictly between "fill" and "drain". An access in the wrong phase does not touch the buffered data. It raises a sticky data-late error instead, and a read returns zero.

The flags live in a companion control/status register. That register also holds the unit select, an address-inhibit bit, a parity-test bit and a group of sticky error flags. Some of those errors (write-check, nonexistent-memory, program and parity) are raised by the transfer engine through a fault input. A write to the status register replaces only its control fields and keeps every error. A write with the clear bit set resets the controller, including the word-count and bus-address registers kept here.

Registers are picked by a 2-bit select: 0 data buffer, 1 control/status, 2 word count, 3 bus address. One access is made per cycle; if write and read strobes coincide, the write is taken.

Top module: `dbuf_handshake`

## Requirements
- R1: After reset the status output reads 0x0040 (only input-ready, bit 6, set) and the read data output reads 0.
- R2: A data-buffer write (select 0) while input-ready is set is accepted: output-ready (bit 7) sets and input-ready clears.
- R3: A data-buffer write while input-ready is clear is discarded: the buffered word is unchanged, and data-late (bit 15) sets.
- R4: A data-buffer read while output-ready is set returns the word last accepted, then clears output-ready and sets input-ready.
- R5: A data-buffer read while output-ready is clear returns 0 and sets data-late.
- R6: A status write (select 1) without the clear bit takes unit select from bits 2:0, address-inhibit from bit 3 and parity-test from bit 4. It sets input-ready, clears output-ready, keeps every error bit (8, 9, 10, 12, 14, 15) and ignores all other written bits.
- R7: A byte write (byte_acc=1) to the odd byte of the status register uses the register's current low byte in place of wdata[7:0]. An even-byte write uses wdata[7:0].
- R8: A status write that selects a unit whose unit_en bit is 0 sets the nonexistent-drive flag (bit 12), which then stays set until a controller reset.
- R9: A status write with the clear bit (bit 5) set resets the controller. Unit, inhibit, parity-test, output-ready and all errors clear, input-ready sets, and word count and bus address become 0. Bit 12 is then set only if unit 0 is disabled. The clear bit always reads as 0.
- R10: A pulse on fault_in[0], [1], [2] or [3] sets status bit 8, 9, 10 or 14 respectively. The bit holds until a controller reset.
- R11: Word count (select 2) and bus address (select 3) are written and read as full words. Reading select 1 returns the status value.
- R12: Read data is registered: the value appears the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 buffer, 1 status, 2 word count, 3 bus address |
| byte_acc | input | 1 | Byte-wide access |
| odd_addr | input | 1 | Byte access targets the odd (upper) byte |
| wdata | input | 16 | Write data |
| unit_en | input | 8 | Per-unit present/enabled bits |
| fault_in | input | 4 | Error pulses from the transfer engine |
| rdata | output | 16 | Registered read data |
| status | output | 16 | Control/status register contents |

## Verification
Every write takes effect at the clock edge that samples the strobe, so status and the stored registers are due one edge after a write. Read data is captured at the edge that samples the read strobe, so it too is due one edge later and must hold through idle cycles after that. The bench drives each access on a falling edge, holds it for one period and samples at the next falling edge, half a period after the updating edge. Fault pulses follow the same one-edge rule.

// File: rtl/dbh_pkg.sv
package dbh_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SEL_DBUF = 2'd0,
    SEL_CSR  = 2'd1,
    SEL_WCNT = 2'd2,
    SEL_BADR = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int B_AIN = 3;
  localparam int B_PAT = 4;
  localparam int B_CLR = 5;
  localparam int B_IR  = 6;
  localparam int B_OR  = 7;
  localparam int B_PAR = 8;
  localparam int B_PGE = 9;
  localparam int B_NEM = 10;
  localparam int B_NED = 12;
  localparam int B_WCE = 14;
  localparam int B_DLT = 15;

  localparam int FAULT_W = 4;
endpackage

// File: rtl/dbh_stages.sv
module dbh_stages #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] older_q,
  output logic [DATA_W-1:0] newer_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      older_q <= '0;
      newer_q <= '0;
    end else if (wr_ok) begin
      newer_q <= wdata;
      older_q <= wdata;
    end else if (rd_ok) begin
      older_q <= newer_q;
    end
  end

  // R3
  stage_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_ok && !rd_ok) |=> ($stable(older_q) && $stable(newer_q)));
endmodule

// File: rtl/dbh_csr.sv
module dbh_csr import dbh_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int UNIT_W = 3,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csr_wr,
  input  logic                 byte_acc,
  input  logic                 odd_addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 db_wr_ok,
  input  logic                 db_rd_ok,
  input  logic                 late,
  input  logic [NUM_UNITS-1:0] unit_en,
  input  logic [FAULT_W-1:0]   fault_in,
  output logic [DATA_W-1:0]    status,
  output logic                 ctl_clr
);
  logic [UNIT_W-1:0] unit_q, unit_nx;
  logic ain_q, pat_q, ir_q, or_q;
  logic par_q, pge_q, nem_q, ned_q, wce_q, dlt_q;
  logic [DATA_W-1:0] wd;
  logic unused_hi;

  always_comb begin
    wd = wdata;
    if (byte_acc && odd_addr) wd[7:0] = status[7:0];
  end
  assign unused_hi = ^wd[DATA_W-1:6];

  assign ctl_clr = csr_wr && wd[B_CLR];
  assign unit_nx = ctl_clr ? '0 : wd[UNIT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q <= '0;
      ain_q  <= 1'b0;
      pat_q  <= 1'b0;
      ir_q   <= 1'b1;
      or_q   <= 1'b0;
      par_q  <= 1'b0;
      pge_q  <= 1'b0;
      nem_q  <= 1'b0;
      ned_q  <= 1'b0;
      wce_q  <= 1'b0;
      dlt_q  <= 1'b0;
    end else begin
      if (csr_wr) begin
        unit_q <= unit_nx;
        ain_q  <= !ctl_clr && wd[B_AIN];
        pat_q  <= !ctl_clr && wd[B_PAT];
        ir_q   <= 1'b1;
        or_q   <= 1'b0;
      end else if (db_wr_ok) begin
        ir_q <= 1'b0;
        or_q <= 1'b1;
      end else if (db_rd_ok) begin
        ir_q <= 1'b1;
        or_q <= 1'b0;
      end
      par_q <= (par_q && !ctl_clr) || fault_in[0];
      pge_q <= (pge_q && !ctl_clr) || fault_in[1];
      nem_q <= (nem_q && !ctl_clr) || fault_in[2];
      wce_q <= (wce_q && !ctl_clr) || fault_in[3];
      ned_q <= (ned_q && !ctl_clr) || (csr_wr && !unit_en[unit_nx]);
      dlt_q <= (dlt_q && !ctl_clr) || late;
    end
  end

  always_comb begin
    status = '0;
    status[UNIT_W-1:0] = unit_q;
    status[B_AIN] = ain_q;
    status[B_PAT] = pat_q;
    status[B_IR]  = ir_q;
    status[B_OR]  = or_q;
    status[B_PAR] = par_q;
    status[B_PGE] = pge_q;
    status[B_NEM] = nem_q;
    status[B_NED] = ned_q;
    status[B_WCE] = wce_q;
    status[B_DLT] = dlt_q;
  end

  // R4
  ready_flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ir_q != or_q);

  // R5
  late_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (dlt_q && !ctl_clr) |=> dlt_q);

  // R6
  csr_wr_ready_chk: assert property (@(posedge clk) disable iff (rst)
    csr_wr |=> (ir_q && !or_q));

  // R8
  ned_set_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !unit_en[unit_nx]) |=> ned_q);
endmodule

// File: rtl/dbh_xregs.sv
module dbh_xregs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wc_wr,
  input  logic              ba_wr,
  input  logic              ctl_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] wc_q,
  output logic [DATA_W-1:0] ba_q
);
  always_ff @(posedge clk) begin
    if (rst || ctl_clr) begin
      wc_q <= '0;
      ba_q <= '0;
    end else begin
      if (wc_wr) wc_q <= wdata;
      if (ba_wr) ba_q <= wdata;
    end
  end

  // R9
  xregs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_clr |=> (wc_q == '0 && ba_q == '0));
endmodule

// File: rtl/dbuf_handshake.sv
module dbuf_handshake import dbh_pkg::*; #(
  parameter int DATA_W = REG_W,
  parameter int UNIT_W = 3,
  localparam int NUM_UNITS = 1 << UNIT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           reg_sel,
  input  logic                 byte_acc,
  input  logic                 odd_addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_UNITS-1:0] unit_en,
  input  logic [FAULT_W-1:0]   fault_in,
  output logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    status
);
  reg_sel_e sel;
  logic rd_act, db_wr, db_rd, wr_ok, rd_ok, late, ctl_clr;
  logic [DATA_W-1:0] older_q, newer_q, wc_q, ba_q;

  assign sel    = reg_sel_e'(reg_sel);
  assign rd_act = rd_en && !wr_en;
  assign db_wr  = wr_en  && (sel == SEL_DBUF);
  assign db_rd  = rd_act && (sel == SEL_DBUF);
  assign wr_ok  = db_wr && status[B_IR];
  assign rd_ok  = db_rd && status[B_OR];
  assign late   = (db_wr && !status[B_IR]) || (db_rd && !status[B_OR]);

  dbh_stages #(.DATA_W(DATA_W)) u_stages (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .rd_ok(rd_ok), .wdata(wdata),
    .older_q(older_q), .newer_q(newer_q)
  );

  dbh_csr #(.DATA_W(DATA_W), .UNIT_W(UNIT_W)) u_csr (
    .clk(clk), .rst(rst), .csr_wr(wr_en && (sel == SEL_CSR)),
    .byte_acc(byte_acc), .odd_addr(odd_addr), .wdata(wdata),
    .db_wr_ok(wr_ok), .db_rd_ok(rd_ok), .late(late),
    .unit_en(unit_en), .fault_in(fault_in),
    .status(status), .ctl_clr(ctl_clr)
  );

  dbh_xregs #(.DATA_W(DATA_W)) u_xregs (
    .clk(clk), .rst(rst),
    .wc_wr(wr_en && (sel == SEL_WCNT)), .ba_wr(wr_en && (sel == SEL_BADR)),
    .ctl_clr(ctl_clr), .wdata(wdata), .wc_q(wc_q), .ba_q(ba_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_act) begin
      case (sel)
        SEL_DBUF: rdata <= rd_ok ? older_q : '0;
        SEL_CSR:  rdata <= status;
        SEL_WCNT: rdata <= wc_q;
        default:  rdata <= ba_q;
      endcase
    end
  end

  // R4
  accepted_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ok |=> (rdata == $past(older_q)));

  // R5
  rejected_read_chk: assert property (@(posedge clk) disable iff (rst)
    (db_rd && !status[B_OR]) |=> (rdata == '0 && status[B_DLT]));

  // R3
  rejected_write_chk: assert property (@(posedge clk) disable iff (rst)
    (db_wr && !status[B_IR]) |=> ($stable(older_q) && $stable(newer_q) && status[B_DLT]));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> $stable(rdata));
endmodule

// File: tb/dbuf_handshake_test.sv
module dbuf_handshake_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, byte_acc = 1'b0, odd_addr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] wdata = '0;
  logic [7:0]  unit_en = 8'hFF;
  logic [3:0]  fault_in = '0;
  logic [15:0] rdata, status;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  dbuf_handshake uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .byte_acc(byte_acc), .odd_addr(odd_addr), .wdata(wdata),
    .unit_en(unit_en), .fault_in(fault_in), .rdata(rdata), .status(status)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %04h expected %04h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [15:0] d,
                        input logic b = 1'b0, input logic o = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wdata = d; byte_acc = b; odd_addr = o;
    @(negedge clk);
    wr_en = 1'b0; byte_acc = 1'b0; odd_addr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 16'h0040);
    chk("R1 rdata", rdata, 16'h0000);
  endtask

  task automatic t_write_read();
    logic [15:0] d;
    bus_wr(2'd0, 16'hA5C3);
    chk("R2 status after write", status, 16'h0080);
    bus_rd(2'd0, d);
    chk("R4 read word", d, 16'hA5C3);
    chk("R4 status after read", status, 16'h0040);
    repeat (3) @(negedge clk);
    chk("R12 rdata held", rdata, 16'hA5C3);
  endtask

  task automatic t_late_write();
    logic [15:0] d;
    bus_wr(2'd0, 16'h1111);
    bus_wr(2'd0, 16'h2222);
    chk("R3 data-late on write", status, 16'h8080);
    bus_rd(2'd0, d);
    chk("R3 word kept", d, 16'h1111);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    bus_wr(2'd2, 16'h1234);
    bus_wr(2'd3, 16'hBEEF);
    bus_rd(2'd2, d);
    chk("R11 word count", d, 16'h1234);
    bus_rd(2'd3, d);
    chk("R11 bus address", d, 16'hBEEF);
    bus_wr(2'd0, 16'h0055);
    bus_wr(2'd1, 16'h0020);
    chk("R9 status after clear", status, 16'h0040);
    bus_rd(2'd2, d);
    chk("R9 word count zero", d, 16'h0000);
    bus_rd(2'd3, d);
    chk("R9 bus address zero", d, 16'h0000);
  endtask

  task automatic t_late_read();
    logic [15:0] d;
    bus_rd(2'd0, d);
    chk("R5 empty read data", d, 16'h0000);
    chk("R5 data-late on read", status, 16'h8040);
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    @(negedge clk); fault_in = 4'hF;
    @(negedge clk); fault_in = 4'h0;
    chk("R10 fault bits", status, 16'hC740);
    bus_wr(2'd0, 16'h0BAD);
    chk("R2 output-ready with errors", status, 16'hC780);
    bus_wr(2'd1, 16'hFF9D);
    chk("R6 status write fields", status, 16'hC75D);
    bus_rd(2'd1, d);
    chk("R11 status read", d, 16'hC75D);
  endtask

  task automatic t_byte();
    bus_wr(2'd1, 16'h1200, 1'b1, 1'b1);
    chk("R7 odd byte merge", status, 16'hC75D);
    bus_wr(2'd1, 16'h0003, 1'b1, 1'b0);
    chk("R7 even byte", status, 16'hC743);
  endtask

  task automatic t_ned();
    unit_en = 8'hDF;
    bus_wr(2'd1, 16'h0005);
    chk("R8 disabled unit", status, 16'hD745);
    bus_wr(2'd1, 16'h0003);
    chk("R8 flag sticky", status, 16'hD743);
    unit_en = 8'hFE;
    bus_wr(2'd1, 16'h0020);
    chk("R9 clear with unit 0 disabled", status, 16'h1040);
    unit_en = 8'hFF;
    bus_wr(2'd1, 16'h0020);
    chk("R9 clear all", status, 16'h0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_late_write();
    t_clear();
    t_late_read();
    t_sticky();
    t_byte();
    t_ned();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule